// File: doc/BRIEF.md
# In-Order Retirement Controller

The block follows every instruction of an out-of-order core from dispatch until it leaves in program order. Each dispatched instruction claims a number of reorder-buffer slots. Its token is written at the slot where that claim begins. It gets a tag, a slot count and a cleared "done" flag. Execution units report completion by naming the token. Each cycle the controller walks forward from the oldest token and retires every done token it meets, up to a programmable per-cycle cap. Each retired token appears on its own retire lane. The unit only signals retirement. Renaming, scheduling and register freeing are handled elsewhere.

Space is tracked as a free-slot count. A dispatch request is normalized before it is checked. Zero becomes one, and anything larger than the buffer becomes the buffer size. The request is accepted only when the free count, as it stood at the start of the cycle, covers the normalized amount. Slots released by retirement therefore become usable in the following cycle.

Top module: `retire_ctrl`

## Requirements
- R1: Tokens retire strictly in dispatch order, oldest first. In a cycle, lane 0 carries the oldest retiring token, lane 1 the next, and so on. Retiring lanes always form a contiguous group starting at bit 0 of `ret_valid`.
- R2: A token retires only after a completion has marked it done, and at the earliest in the cycle after that completion. The walk in a cycle stops at the first token that is not done, even if younger tokens are done.
- R3: A dispatched token takes its normalized slot count out of the free count. Those slots come back when it retires. `free_slots` never exceeds DEPTH.
- R4: A slot request of 0 is treated as 1, and a request above DEPTH is treated as DEPTH.
- R5: `disp_ready` is high exactly when `free_slots` is at least the normalized request. A request with `disp_ready` low changes nothing.
- R6: `max_retire` caps the number of retirements per cycle. A value of 0 removes the cap.
- R7: `empty` is high exactly when `free_slots` equals DEPTH. When `empty` is high, nothing retires.
- R8: Token IDs are IDX_W+1 bits wide, and only values below DEPTH name a token. The all-ones ID marks an untracked instruction. A completion with that ID, with any other ID of DEPTH or more, or with the ID of a slot holding no token, has no effect.
- R9: The first token after reset gets ID 0. Each later token gets the previous ID plus the previous token's normalized slot count, modulo DEPTH. `disp_token` shows the ID the next accepted dispatch will get.
- R10: When a dispatch and retirements happen in the same cycle, the free count changes by (slots freed − slots claimed). Slots freed in a cycle cannot be claimed by a dispatch in that same cycle.
- R11: A completion for a token that is already done, or two completions for the same token in one cycle, have the same effect as a single completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Instruction tag carried by the token |
| disp_slots | input | REQ_W | Requested reorder-buffer slots, before normalization |
| disp_ready | output | 1 | Enough free slots for the normalized request |
| disp_token | output | IDX_W+1 | ID that the next accepted dispatch receives |
| cmpl_valid | input | NCMP | One bit per completion port |
| cmpl_id | input | NCMP*(IDX_W+1) | Token ID per completion port; port c uses bits c*(IDX_W+1) upward |
| max_retire | input | CNT_W | Per-cycle retirement cap; 0 means no cap |
| ret_valid | output | DEPTH | Lane k retires a token this cycle |
| ret_tag | output | DEPTH*TAG_W | Tag of the token on lane k |
| ret_token | output | DEPTH*(IDX_W+1) | ID of the token on lane k |
| free_slots | output | CNT_W | Free reorder-buffer slots |
| empty | output | 1 | No token in flight |

## Verification
The assertions check four properties on every cycle: the free count stays within bounds, retire lanes are contiguous, the per-cycle cap is respected, and every retiring lane names a done token. They also check that nothing retires while empty and that completions aimed only at the sentinel ID set no done flags. Other behaviours only the bench scenarios can show, because they need a model of program order. These are the retire order and tags, the stop at the oldest unfinished token, clamping seen through token IDs and free counts, the wrap of token IDs, and the rule that slots freed in a cycle cannot be claimed in that same cycle. The bench sweeps every cap value over a full buffer and then runs a long mixed stream of multi-slot dispatches and completions.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
  localparam int unsigned RC_DEPTH_DEF = 8;
  localparam int unsigned RC_TAG_W_DEF = 4;
  localparam int unsigned RC_REQ_W_DEF = 4;
  localparam int unsigned RC_NCMP_DEF  = 2;

  // advance a ring position by n (n <= depth), modulo depth
  function automatic int unsigned rc_wrap(input int unsigned p,
                                          input int unsigned n,
                                          input int unsigned depth);
    int unsigned s;
    s = p + n;
    return (s >= depth) ? (s - depth) : s;
  endfunction
endpackage

// File: rtl/rc_slot_norm.sv
`timescale 1ns/1ps
module rc_slot_norm #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned REQ_W = 4,
  parameter int unsigned CNT_W = 4
) (
  input  logic [REQ_W-1:0] req,
  output logic [CNT_W-1:0] cnt
);
  // clamp the request into [1, DEPTH]
  always_comb begin
    if (req == '0) begin
      cnt = CNT_W'(1);
    end else if (32'(req) > DEPTH) begin
      cnt = CNT_W'(DEPTH);
    end else begin
      cnt = CNT_W'(req);
    end
  end
endmodule

// File: rtl/rc_retire_sel.sv
`timescale 1ns/1ps
module rc_retire_sel
  import rc_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic [IDX_W-1:0] head,
  input  logic [CNT_W-1:0] occ,
  input  logic [CNT_W-1:0] lim,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] done,
  input  logic [CNT_W-1:0] nsl [DEPTH],
  output logic [DEPTH-1:0] go,
  output logic [IDX_W-1:0] idx [DEPTH],
  output logic [CNT_W-1:0] freed
);
  // walk tokens from the head; each lane follows the previous token's slot span
  always_comb begin
    int unsigned p;
    int unsigned sum;
    int unsigned n;
    logic        alive;
    logic [IDX_W-1:0] pi;
    p     = 32'(head);
    sum   = 0;
    alive = 1'b1;
    go    = '0;
    for (int k = 0; k < int'(DEPTH); k++) begin
      pi     = IDX_W'(p);
      idx[k] = pi;
      n      = 32'(nsl[pi]);
      if (alive && (sum < 32'(occ)) && vld[pi] && done[pi] &&
          ((lim == '0) || (k < int'(lim)))) begin
        go[k] = 1'b1;
        sum   = sum + n;
        p     = rc_wrap(p, n, DEPTH);
      end else begin
        alive = 1'b0;
      end
    end
    freed = CNT_W'(sum);
  end
endmodule

// File: rtl/retire_ctrl.sv
`timescale 1ns/1ps
module retire_ctrl
  import rc_pkg::*;
#(
  parameter int unsigned DEPTH = RC_DEPTH_DEF,
  parameter int unsigned TAG_W = RC_TAG_W_DEF,
  parameter int unsigned REQ_W = RC_REQ_W_DEF,
  parameter int unsigned NCMP  = RC_NCMP_DEF,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned TID_W = IDX_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    disp_valid,
  input  logic [TAG_W-1:0]        disp_tag,
  input  logic [REQ_W-1:0]        disp_slots,
  output logic                    disp_ready,
  output logic [TID_W-1:0]        disp_token,
  input  logic [NCMP-1:0]         cmpl_valid,
  input  logic [NCMP*TID_W-1:0]   cmpl_id,
  input  logic [CNT_W-1:0]        max_retire,
  output logic [DEPTH-1:0]        ret_valid,
  output logic [DEPTH*TAG_W-1:0]  ret_tag,
  output logic [DEPTH*TID_W-1:0]  ret_token,
  output logic [CNT_W-1:0]        free_slots,
  output logic                    empty
);
  // token state, indexed by the slot where each token starts
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] done_q, done_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CNT_W-1:0] nsl_q [DEPTH];
  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] free_q, free_d;

  logic [CNT_W-1:0] disp_n;
  logic             fire;
  logic [CNT_W-1:0] occ;
  logic [DEPTH-1:0] go;
  logic [IDX_W-1:0] lidx [DEPTH];
  logic [CNT_W-1:0] freed;

  rc_slot_norm #(.DEPTH(DEPTH), .REQ_W(REQ_W), .CNT_W(CNT_W)) u_norm (
    .req (disp_slots),
    .cnt (disp_n)
  );

  assign occ = CNT_W'(DEPTH) - free_q;

  rc_retire_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sel (
    .head  (head_q),
    .occ   (occ),
    .lim   (max_retire),
    .vld   (vld_q),
    .done  (done_q),
    .nsl   (nsl_q),
    .go    (go),
    .idx   (lidx),
    .freed (freed)
  );

  // gate uses the free count held at the start of the cycle
  assign disp_ready = (free_q >= disp_n);
  assign fire       = disp_valid && disp_ready;

  // next-state logic
  always_comb begin
    logic [TID_W-1:0] cid;
    vld_d  = vld_q;
    done_d = done_q;
    for (int k = 0; k < int'(DEPTH); k++) begin
      if (go[k]) begin
        vld_d[lidx[k]]  = 1'b0;
        done_d[lidx[k]] = 1'b0;
      end
    end
    for (int c = 0; c < int'(NCMP); c++) begin
      cid = cmpl_id[c*TID_W +: TID_W];
      if (cmpl_valid[c] && (32'(cid) < DEPTH)) begin
        if (vld_d[IDX_W'(cid)]) begin
          done_d[IDX_W'(cid)] = 1'b1;
        end
      end
    end
    if (fire) begin
      vld_d[tail_q]  = 1'b1;
      done_d[tail_q] = 1'b0;
    end
    tail_d = fire ? IDX_W'(rc_wrap(32'(tail_q), 32'(disp_n), DEPTH)) : tail_q;
    head_d = IDX_W'(rc_wrap(32'(head_q), 32'(freed), DEPTH));
    free_d = free_q + freed - (fire ? disp_n : CNT_W'(0));
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(DEPTH);
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
      head_q <= head_d;
      tail_q <= tail_d;
      free_q <= free_d;
    end
  end

  // payload registers: enabled writes, no reset
  always_ff @(posedge clk) begin
    if (fire) begin
      tag_q[tail_q] <= disp_tag;
      nsl_q[tail_q] <= disp_n;
    end
  end

  assign disp_token = TID_W'(tail_q);
  assign free_slots = free_q;
  assign empty      = (free_q == CNT_W'(DEPTH));
  assign ret_valid  = go;

  for (genvar k = 0; k < int'(DEPTH); k++) begin : g_lane
    assign ret_tag[k*TAG_W +: TAG_W]   = tag_q[lidx[k]];
    assign ret_token[k*TID_W +: TID_W] = TID_W'(lidx[k]);

    // R2: a retiring lane names a token already marked done
    a_r2_lane_done: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[k] |-> done_q[lidx[k]]);
  end

  // completions that all carry the untracked ID
  logic sen_only;
  always_comb begin
    sen_only = 1'b1;
    for (int c = 0; c < int'(NCMP); c++) begin
      if (cmpl_valid[c] && (cmpl_id[c*TID_W +: TID_W] != {TID_W{1'b1}})) begin
        sen_only = 1'b0;
      end
    end
  end

  a_r3_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= CNT_W'(DEPTH));

  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (ret_valid == '0));

  a_r6_retire_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (max_retire != '0) |-> ($countones(ret_valid) <= int'(max_retire)));

  a_r1_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
    ((DEPTH'(ret_valid + 1'b1) & ret_valid) == '0));

  a_r8_sentinel_inert: assert property (@(posedge clk) disable iff (!rst_n)
    sen_only |=> ((done_q & ~$past(done_q)) == '0));
endmodule

// File: tb/sim_retire_ctrl.sv
`timescale 1ns/1ps
module sim_retire_ctrl;
  localparam int DEPTH = 8;
  localparam int TAG_W = 4;
  localparam int TID_W = 4;
  localparam int CNT_W = 4;
  localparam int QM    = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             disp_valid;
  logic [3:0]       disp_tag;
  logic [3:0]       disp_slots;
  logic             disp_ready;
  logic [3:0]       disp_token;
  logic [1:0]       cmpl_valid;
  logic [7:0]       cmpl_id;
  logic [3:0]       max_retire;
  logic [7:0]       ret_valid;
  logic [31:0]      ret_tag;
  logic [31:0]      ret_token;
  logic [3:0]       free_slots;
  logic             empty;

  always #10 clk = ~clk;

  retire_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_slots(disp_slots),
    .disp_ready(disp_ready), .disp_token(disp_token),
    .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .max_retire(max_retire),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_token(ret_token),
    .free_slots(free_slots), .empty(empty)
  );

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  // reference model: in-flight tokens by sequence number
  int m_tag [QM];
  int m_n   [QM];
  int m_idx [QM];
  bit m_ex  [QM];
  int mh = 0, mt = 0;
  int mtail = 0;
  int mfree = DEPTH;

  function automatic int norm(input int s);
    if (s == 0) return 1;
    if (s > DEPTH) return DEPTH;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string lbl);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, lbl, act, exp);
    end
  endtask

  task automatic apply_cmpl(input bit v, input int id);
    if (v && id < DEPTH) begin
      for (int j = mh; j < mt; j++) begin
        if (m_idx[j % QM] == id) m_ex[j % QM] = 1'b1;
      end
    end
  endtask

  task automatic step(input bit dv, input int tg, input int sl,
                      input bit c0v, input int c0, input bit c1v, input int c1,
                      input int lim, input string lbl);
    int n;
    int k;
    int j;
    bit rdy;
    int etag [DEPTH];
    int etok [DEPTH];
    @(negedge clk);
    disp_valid = dv;
    disp_tag   = 4'(tg);
    disp_slots = 4'(sl);
    cmpl_valid = {c1v, c0v};
    cmpl_id    = {4'(c1), 4'(c0)};
    max_retire = 4'(lim);
    #1;
    n   = norm(sl);
    rdy = (mfree >= n);
    k = 0;
    j = mh;
    while (j < mt && m_ex[j % QM] && (lim == 0 || k < lim)) begin
      etag[k] = m_tag[j % QM];
      etok[k] = m_idx[j % QM];
      k++;
      j++;
    end
    chk("R2 R6 lanes", int'(ret_valid), (1 << k) - 1, lbl);
    for (int l = 0; l < k; l++) begin
      chk("R1 tag", int'(ret_tag[l*TAG_W +: TAG_W]), etag[l], lbl);
      chk("R9 retire id", int'(ret_token[l*TID_W +: TID_W]), etok[l], lbl);
    end
    chk("R4 R5 ready", int'(disp_ready), int'(rdy), lbl);
    chk("R9 next id", int'(disp_token), mtail, lbl);
    chk("R3 R10 free", int'(free_slots), mfree, lbl);
    chk("R7 empty", int'(empty), int'(mfree == DEPTH), lbl);
    @(posedge clk);
    for (int r = 0; r < k; r++) begin
      mfree += m_n[mh % QM];
      mh++;
    end
    apply_cmpl(c0v, c0);
    apply_cmpl(c1v, c1);
    if (dv && rdy) begin
      m_tag[mt % QM] = tg & 15;
      m_n[mt % QM]   = n;
      m_idx[mt % QM] = mtail;
      m_ex[mt % QM]  = 1'b0;
      mt++;
      mtail = (mtail + n) % DEPTH;
      mfree -= n;
    end
  endtask

  task automatic idle(input int lim, input string lbl);
    step(0, 0, 1, 0, 0, 0, 0, lim, lbl);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    disp_valid = 1'b0; disp_tag = '0; disp_slots = '0;
    cmpl_valid = '0; cmpl_id = '0; max_retire = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    idle(0, "R7 reset");
    // R4 zero request claims one slot
    step(1, 1, 0, 0, 0, 0, 0, 0, "R4 zero");
    // R5 oversize request clamps to 8 but only 7 free
    step(1, 2, 15, 0, 0, 0, 0, 0, "R5 R4 oversize");
    step(1, 3, 3, 0, 0, 0, 0, 0, "R9 three");
    step(1, 4, 5, 0, 0, 0, 0, 0, "R5 short");
    // R9 this dispatch fills the ring and wraps the next ID to 0
    step(1, 5, 4, 0, 0, 0, 0, 0, "R9 wrap");
    idle(0, "R3 full");
    // R2 younger tokens done, oldest not
    step(0, 0, 1, 1, 4, 1, 1, 0, "R2 younger");
    idle(0, "R2 blocked");
    // R8 sentinel and out-of-range IDs
    step(0, 0, 1, 1, 15, 1, 9, 0, "R8 sentinel");
    idle(0, "R8 after");
    // R11 duplicate completion in one cycle
    step(0, 0, 1, 1, 0, 1, 0, 0, "R11 dup");
    // R10 all retire now; freed slots not claimable in this cycle
    step(1, 6, 2, 0, 0, 0, 0, 0, "R10 same cycle");
    step(1, 6, 2, 1, 0, 0, 0, 0, "R10 next cycle");
    step(0, 0, 1, 1, 0, 0, 0, 0, "R11 repeat");
    idle(0, "R11 drain");
    idle(0, "R7 drained");

    // R6 sweep of every cap over a full ring of one-slot tokens
    for (int lim = 0; lim <= DEPTH; lim++) begin
      for (int t = 0; t < DEPTH; t++) step(1, t, 1, 0, 0, 0, 0, lim, "R6 fill");
      for (int t = 0; t < DEPTH; t += 2)
        step(0, 0, 1, 1, (mtail + t) % DEPTH, 1, (mtail + t + 1) % DEPTH, lim, "R6 done");
      for (int t = 0; t < DEPTH + 1; t++) idle(lim, "R6 drain");
    end

    // R10 R11 mixed stream of multi-slot traffic
    for (int i = 0; i < 3000; i++) begin
      int c0, c1;
      bit v0, v1;
      v0 = ($urandom_range(0, 3) != 0);
      v1 = ($urandom_range(0, 2) == 0);
      c0 = (mt > mh && $urandom_range(0, 9) < 8) ?
           m_idx[$urandom_range(mh, mt - 1) % QM] : int'($urandom_range(0, 15));
      c1 = (mt > mh && $urandom_range(0, 1) == 0) ?
           m_idx[$urandom_range(mh, mt - 1) % QM] : int'($urandom_range(0, 15));
      step($urandom_range(0, 2) != 0, int'($urandom_range(0, 15)),
           ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 3)),
           v0, c0, v1, c1, int'($urandom_range(0, DEPTH)), "R10 mix");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule